// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table kept in memory. A requester hands it the 20-bit virtual page number that missed. The walker splits that number into a directory index and a table index. It reads the directory entry first, then the page table entry that the directory entry points to. Each read goes out through a single memory read port. The block returns either the final page table entry, which is ready to load into the TLB, or a fault that says which level held an invalid entry.

Privileged software programs the physical byte address of the directory on a plain input. Only one walk is in flight at a time. The miss request and the result both use valid/ready handshakes:

- **Miss request:** the request is taken on an edge where `req_valid` and `req_ready` are both high.
- **Result:** the result is offered on `rsp_valid` and held unchanged until `rsp_ready` takes it.

The memory request side uses valid/ready as well. Read data comes back on a one-cycle `mem_rsp_valid` strobe after any number of cycles.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The directory index is `req_vpn[19:10]` and the table index is `req_vpn[9:0]`. Entries are 4 bytes.
  - The first read is at `root_base + 4*directory index`.
  - The second read is at `{directory entry[31:12], 12'h000} + 4*table index`.
- R3: In an entry, bit 0 is the valid flag and bits 31:12 are the frame number. The walker does not interpret any other bit.
- R4: If both entries are valid, the result has `rsp_fault` = 0 and `rsp_pte` equal to the page table entry exactly as read.
- R5: An invalid directory entry ends the walk after one read. The result is `rsp_fault` = 1, `rsp_fault_lvl` = 0, and `rsp_pte` equal to the directory entry.
- R6: An invalid page table entry gives `rsp_fault` = 1, `rsp_fault_lvl` = 1, and `rsp_pte` equal to that entry.
- R7: Once `mem_req_valid` rises, it stays high and `mem_req_addr` stays stable until the edge where `mem_req_ready` is high.
- R8: Suppose memory grants each request at once and answers in the next cycle. Then `rsp_valid` rises 4 cycles after the edge that accepted the miss. Each cycle of withheld `mem_req_ready` adds one cycle, and so does each extra cycle of read latency.
- R9: `req_ready` is 0 from the accepting edge until the edge where the result is taken. It is 1 again in the cycle after that edge.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the signals `rsp_valid`, `rsp_pte`, `rsp_fault` and `rsp_fault_lvl` hold their values.
- R11: `root_base` is sampled on the accepting edge. A change to it during a walk does not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_base | input | 32 | Physical byte address of the directory (privileged register) |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | 20 | Virtual page number that missed |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Walk result offered |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pte | output | 32 | Final entry, or the invalid entry on a fault |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |

## Verification
With zero-wait memory, the result is due 4 cycles after the accepting edge. Each stalled grant cycle and each extra latency cycle moves it one cycle later. The bench derives the expected arrival cycle from the stall and latency it programmed into its memory model, counts edges from acceptance, and compares that count exactly. Outputs and the memory model are sampled on the falling edge. So each check, including the read address log and the stability checks during result back-pressure, sees settled values one full half-period after the register updates. The `req_ready` recovery is checked in the cycle right after the result handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PAGE_BITS = 12;
  localparam int IDX_BITS  = 10;
  localparam int ENT_BITS  = 32;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD_DIR = 3'd1,
    S_WT_DIR = 3'd2,
    S_RD_PTE = 3'd3,
    S_WT_PTE = 3'd4,
    S_DONE   = 3'd5,
    S_FAULT  = 3'd6
  } ptw_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } ptw_lvl_e;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int PAGE_W = PAGE_BITS,
  parameter int IDX_W  = IDX_BITS,
  parameter int ENT_W  = ENT_BITS
) (
  input  ptw_lvl_e                lvl,
  input  logic [ENT_W-1:0]        root,
  input  logic [ENT_W-PAGE_W-1:0] frame,
  input  logic [2*IDX_W-1:0]      vpn,
  output logic [ENT_W-1:0]        addr
);
  localparam int ENT_SH = $clog2(ENT_W / 8);

  logic [IDX_W-1:0] idx;
  logic [ENT_W-1:0] base;
  logic [ENT_W-1:0] ofs;

  always_comb begin
    if (lvl == LVL_DIR) begin
      idx  = vpn[2*IDX_W-1:IDX_W];
      base = root;
    end else begin
      idx  = vpn[IDX_W-1:0];
      base = {frame, {PAGE_W{1'b0}}};
    end
    ofs  = ENT_W'(idx) << ENT_SH;
    addr = base + ofs;
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  output logic     req_ready,
  output logic     accept,
  output logic     mem_req_valid,
  input  logic     mem_req_ready,
  input  logic     mem_rsp_valid,
  input  logic     entry_ok,
  output logic     cap_ent,
  output ptw_lvl_e lvl,
  output logic     rsp_valid,
  input  logic     rsp_ready,
  output logic     rsp_fault,
  output ptw_lvl_e fault_lvl
);
  ptw_state_e state_q, state_d;
  ptw_lvl_e   flvl_q, flvl_d;

  always_comb begin
    state_d = state_q;
    flvl_d  = flvl_q;
    case (state_q)
      S_IDLE:   if (req_valid) state_d = S_RD_DIR;
      S_RD_DIR: if (mem_req_ready) state_d = S_WT_DIR;
      S_WT_DIR: if (mem_rsp_valid) begin
        if (entry_ok) state_d = S_RD_PTE;
        else begin
          state_d = S_FAULT;
          flvl_d  = LVL_DIR;
        end
      end
      S_RD_PTE: if (mem_req_ready) state_d = S_WT_PTE;
      S_WT_PTE: if (mem_rsp_valid) begin
        if (entry_ok) state_d = S_DONE;
        else begin
          state_d = S_FAULT;
          flvl_d  = LVL_TBL;
        end
      end
      S_DONE, S_FAULT: if (rsp_ready) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      flvl_q  <= LVL_DIR;
    end else begin
      state_q <= state_d;
      flvl_q  <= flvl_d;
    end
  end

  always_comb begin
    req_ready     = (state_q == S_IDLE);
    accept        = req_ready && req_valid;
    mem_req_valid = (state_q == S_RD_DIR) || (state_q == S_RD_PTE);
    lvl           = ((state_q == S_RD_DIR) || (state_q == S_WT_DIR)) ? LVL_DIR : LVL_TBL;
    cap_ent       = mem_rsp_valid && ((state_q == S_WT_DIR) || (state_q == S_WT_PTE));
    rsp_valid     = (state_q == S_DONE) || (state_q == S_FAULT);
    rsp_fault     = (state_q == S_FAULT);
    fault_lvl     = flvl_q;
  end

  // R9: an idle walker drives neither a memory read nor a result
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  // R9: the walker is idle again right after the result handshake
  a_r9_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);

  // R10: a stalled result keeps its status
  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(fault_lvl)));

  // R7: a memory request is not withdrawn before it is granted
  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int PAGE_W    = PAGE_BITS,
  parameter int IDX_W     = IDX_BITS,
  parameter int ENT_W     = ENT_BITS,
  parameter int VALID_BIT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ENT_W-1:0]     root_base,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2*IDX_W-1:0]   req_vpn,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ENT_W-1:0]     mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [ENT_W-1:0]     mem_rsp_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [ENT_W-1:0]     rsp_pte,
  output logic                 rsp_fault,
  output logic                 rsp_fault_lvl
);
  localparam int VPN_W = 2 * IDX_W;

  logic [VPN_W-1:0] vpn_q;
  logic [ENT_W-1:0] root_q;
  logic [ENT_W-1:0] ent_q;
  logic             accept;
  logic             cap_ent;
  logic             entry_ok;
  ptw_lvl_e         lvl;
  ptw_lvl_e         fault_lvl;

  assign entry_ok = mem_rsp_data[VALID_BIT];

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .accept        (accept),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_ok      (entry_ok),
    .cap_ent       (cap_ent),
    .lvl           (lvl),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .fault_lvl     (fault_lvl)
  );

  ptw_addr #(
    .PAGE_W (PAGE_W),
    .IDX_W  (IDX_W),
    .ENT_W  (ENT_W)
  ) u_addr (
    .lvl   (lvl),
    .root  (root_q),
    .frame (ent_q[ENT_W-1:PAGE_W]),
    .vpn   (vpn_q),
    .addr  (mem_req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      root_q <= '0;
      ent_q  <= '0;
    end else begin
      if (accept) begin
        vpn_q  <= req_vpn;
        root_q <= root_base;
      end
      if (cap_ent) ent_q <= mem_rsp_data;
    end
  end

  assign rsp_pte       = ent_q;
  assign rsp_fault_lvl = (fault_lvl == LVL_TBL);

  // R7: address stable while the read waits for a grant
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R10: the returned entry holds under back-pressure
  a_r10_pte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_pte));

  // R4: a successful result carries a valid entry
  a_r4_ok_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_pte[VALID_BIT]);

  // R5: a fault always reports an entry whose valid flag is clear
  a_r5_fault_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !rsp_pte[VALID_BIT]);
endmodule

// File: tb/ptw_top_bench.sv
module ptw_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pte;
  logic        rsp_fault;
  logic        rsp_fault_lvl;

  always #5 clk = ~clk;

  ptw_top u_ptw_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_base     (root_base),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vpn       (req_vpn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_pte       (rsp_pte),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem_q [logic [31:0]];
  int          stall_cfg = 0;
  int          lat_cfg   = 0;
  int          stall_left = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [2];
  int          hold_viol = 0;
  bit          acc_prev = 0;
  bit          wait_prev = 0;
  logic [31:0] addr_prev = '0;
  bit          pend = 0;
  int          lat_left = 0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return 32'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (acc_prev) begin
        pend      = 1;
        lat_left  = lat_cfg;
        pend_addr = addr_prev;
        if (rd_cnt < 2) rd_addr[rd_cnt] = addr_prev;
        rd_cnt++;
        stall_left = stall_cfg;
      end
      if (pend) begin
        if (lat_left == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_rd(pend_addr);
          pend = 0;
        end else lat_left--;
      end
      if (wait_prev && mem_req_valid && (mem_req_addr !== addr_prev)) hold_viol++;
      acc_prev  = 0;
      wait_prev = 0;
      mem_req_ready = 1'b0;
      if (mem_req_valid) begin
        addr_prev = mem_req_addr;
        if (stall_left > 0) begin
          stall_left--;
          wait_prev = 1;
        end else begin
          mem_req_ready = 1'b1;
          acc_prev = 1;
        end
      end
    end
  end

  // walk driver; results left in obs_*
  logic [31:0] obs_pte;
  logic        obs_fault;
  logic        obs_lvl;
  int          obs_n;
  int          obs_unstable;

  task automatic do_walk(input logic [19:0] vpn, input logic [31:0] root, input int stall,
                         input int lat, input int hold, input logic [31:0] root_late);
    @(negedge clk);
    stall_cfg  = stall;
    stall_left = stall;
    lat_cfg    = lat;
    rd_cnt     = 0;
    rd_addr[0] = 'x;
    rd_addr[1] = 'x;
    hold_viol  = 0;
    root_base  = root;
    req_vpn    = vpn;
    req_valid  = 1'b1;
    rsp_ready  = 1'b0;
    obs_n = 0;
    obs_unstable = 0;
    while (1) begin
      @(posedge clk);
      obs_n++;
      @(negedge clk);
      if (obs_n == 1) begin
        req_valid = 1'b0;
        root_base = root_late;
      end
      if (rsp_valid) break;
      if (req_ready) obs_unstable++;
    end
    obs_pte   = rsp_pte;
    obs_fault = rsp_fault;
    obs_lvl   = rsp_fault_lvl;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_pte !== obs_pte || rsp_fault !== obs_fault ||
          rsp_fault_lvl !== obs_lvl || req_ready) obs_unstable++;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_basic;
    do_walk({10'h003, 10'h005}, 32'h0001_0000, 0, 0, 0, 32'h0001_0000);
    chk("R2 dir addr", rd_addr[0], 32'h0001_000C);
    chk("R2 R3 tbl addr", rd_addr[1], 32'h0002_0014);
    chk("R4 pte", obs_pte, 32'h0ABC_D007);
    chk("R4 fault", {31'b0, obs_fault}, 32'd0);
    chk("R8 latency zero-wait", obs_n, 32'd5);
    chk("R9 busy req_ready", obs_unstable, 32'd0);
    chk("R9 ready after take", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_dir_fault;
    do_walk({10'h004, 10'h001}, 32'h0001_0000, 0, 0, 0, 32'h0001_0000);
    chk("R5 fault", {31'b0, obs_fault}, 32'd1);
    chk("R5 level", {31'b0, obs_lvl}, 32'd0);
    chk("R5 pte", obs_pte, 32'h0003_0006);
    chk("R5 one read", rd_cnt, 32'd1);
  endtask

  task automatic t_tbl_fault;
    do_walk({10'h003, 10'h006}, 32'h0001_0000, 0, 0, 0, 32'h0001_0000);
    chk("R6 fault", {31'b0, obs_fault}, 32'd1);
    chk("R6 level", {31'b0, obs_lvl}, 32'd1);
    chk("R6 pte", obs_pte, 32'h0BAD_0002);
    chk("R6 two reads", rd_cnt, 32'd2);
  endtask

  task automatic t_slow_mem;
    do_walk({10'h003, 10'h005}, 32'h0001_0000, 3, 2, 0, 32'h0001_0000);
    chk("R8 latency slow", obs_n, 32'd15);
    chk("R7 addr hold", hold_viol, 32'd0);
    chk("R7 tbl addr", rd_addr[1], 32'h0002_0014);
    chk("R4 pte slow", obs_pte, 32'h0ABC_D007);
  endtask

  task automatic t_backpressure;
    do_walk({10'h003, 10'h005}, 32'h0001_0000, 0, 1, 4, 32'h0001_0000);
    chk("R10 hold stable", obs_unstable, 32'd0);
    chk("R10 rsp dropped after take", {31'b0, rsp_valid}, 32'd0);
    chk("R9 ready after backpressure", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_root_change;
    do_walk({10'h003, 10'h005}, 32'h0001_0000, 1, 0, 0, 32'h0005_0000);
    chk("R11 dir addr old root", rd_addr[0], 32'h0001_000C);
    chk("R11 pte", obs_pte, 32'h0ABC_D007);
    root_base = 32'h0001_0000;
  endtask

  task automatic t_index_edges;
    do_walk(20'hFFFFF, 32'h7000_0000, 0, 0, 0, 32'h7000_0000);
    chk("R2 max dir addr", rd_addr[0], 32'h7000_0FFC);
    chk("R2 max tbl addr", rd_addr[1], 32'h0004_0FFC);
    chk("R3 pte max", obs_pte, 32'h1234_5001);
    do_walk(20'h00000, 32'h7000_0000, 0, 0, 0, 32'h7000_0000);
    chk("R2 zero dir addr", rd_addr[0], 32'h7000_0000);
    chk("R2 zero tbl addr", rd_addr[1], 32'h0005_0000);
    chk("R3 pte zero", obs_pte, 32'h0000_1F01);
  endtask

  initial begin
    mem_q[32'h0001_000C] = 32'h0002_0003;
    mem_q[32'h0002_0014] = 32'h0ABC_D007;
    mem_q[32'h0001_0010] = 32'h0003_0006;
    mem_q[32'h0002_0018] = 32'h0BAD_0002;
    mem_q[32'h7000_0FFC] = 32'h0004_0001;
    mem_q[32'h0004_0FFC] = 32'h1234_5001;
    mem_q[32'h7000_0000] = 32'h0005_0001;
    mem_q[32'h0005_0000] = 32'h0000_1F01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_dir_fault;
    t_tbl_fault;
    t_slow_mem;
    t_backpressure;
    t_root_change;
    t_index_edges;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule